// File: doc/BRIEF.md
# Dual PWM and Toggle Timer

This block is a pair of 8-bit counting channels that work either side by side or chained into one 16-bit timer. Each channel drives one waveform pin: the low channel drives `wave_lo` and the high channel drives `wave_hi`. A pin either inverts at the end of every period (toggle) or carries a pulse-width-modulated waveform. The 2-bit `mode` input selects how the channels are combined and what each pin carries. Each channel also raises a one-cycle match flag when its period ends.

In the chained modes, the high channel advances only when the low channel finishes a period. The full 16-bit period is therefore (period_lo+1) × (period_hi+1) cycles, and the low channel keeps its own output, either a toggle or a PWM waveform.

Period and duty are sampled into shadow registers. A change made while the timer runs is applied only when the current period ends. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal that is sampled or updated on each rising clock edge.

Top module: `twin_wave_timer`

## Requirements
- R1: After reset both waveform pins and both match flags are low.
- R2: If `en` is low at a clock edge, all four outputs are low from the next cycle on and the counters return to zero. After `en` rises, a toggle pin first inverts period+2 cycles after the rising edge is driven.
- R3: In mode 2'b00 each channel counts 0..period on its own, and its pin inverts once every period+1 cycles.
- R4: In mode 2'b01 each pin is a PWM waveform with a period of period+1 cycles. The pin is high while the count is below duty, which gives min(duty, period+1) high cycles at the start of each period.
- R5: A PWM duty of 0 keeps the pin low. A duty larger than the period keeps the pin high.
- R6: In mode 2'b10 the low pin toggles every period_lo+1 cycles. The high channel counts low-channel matches, so the high pin toggles every (period_lo+1)×(period_hi+1) cycles.
- R7: In mode 2'b11 the low pin is the PWM waveform of the low channel. The high pin toggles at the chained 16-bit period.
- R8: Each match flag is high for exactly one cycle at the start of every new period of its channel. In the chained modes `match_hi` is never high without `match_lo`.
- R9: If period or duty changes in the middle of a period, the period already running keeps its old values. The following period uses the new values.
- R10: A mode change made while `en` is low takes effect from the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low clears counters and outputs |
| mode | input | 2 | 00 dual toggle, 01 dual PWM, 10 chained toggle, 11 chained with low PWM |
| period_lo | input | W | Low channel period (count limit) |
| period_hi | input | W | High channel period (count limit) |
| duty_lo | input | W | Low channel PWM duty |
| duty_hi | input | W | High channel PWM duty |
| wave_lo | output | 1 | Low channel waveform pin |
| wave_hi | output | 1 | High channel waveform pin |
| match_lo | output | 1 | Low channel end-of-period flag |
| match_hi | output | 1 | High channel end-of-period flag |

## Verification
The assertions assume that `mode` stays constant while `en` is high, and one property checks that rule on the inputs. The toggle and chaining properties are valid only under that assumption. The bench follows the same rule: every scenario drops `en`, loads mode, period and duty, and only then raises `en` again. The only values it changes during a run are period and duty, which is the buffering case.

// File: rtl/twt_pkg.sv
package twt_pkg;

  typedef enum logic [1:0] {
    TWT_DUAL_TOGGLE = 2'b00,
    TWT_DUAL_PWM    = 2'b01,
    TWT_WIDE_TOGGLE = 2'b10,
    TWT_WIDE_PWM    = 2'b11
  } twt_mode_e;

  function automatic logic twt_lo_pwm(input twt_mode_e m);
    return (m == TWT_DUAL_PWM) || (m == TWT_WIDE_PWM);
  endfunction

  function automatic logic twt_hi_pwm(input twt_mode_e m);
    return (m == TWT_DUAL_PWM);
  endfunction

  function automatic logic twt_chained(input twt_mode_e m);
    return (m == TWT_WIDE_TOGGLE) || (m == TWT_WIDE_PWM);
  endfunction

endpackage

// File: rtl/twt_chan.sv
module twt_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic         hit,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per_sh,
  output logic [W-1:0] duty_sh
);

  logic at_end;

  assign at_end = (cnt == per_sh);
  assign hit    = en & run & step & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_sh  <= '0;
      duty_sh <= '0;
    end else if (!en || !run) begin
      cnt     <= '0;
      per_sh  <= per_in;
      duty_sh <= duty_in;
    end else if (step) begin
      if (at_end) begin
        cnt     <= '0;
        per_sh  <= per_in;
        duty_sh <= duty_in;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end

endmodule

// File: rtl/twt_wave.sv
module twt_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         run,
  input  logic         pwm_mode,
  input  logic         hit,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty_sh,
  output logic         wave,
  output logic         flag
);

  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      flag <= en & hit;
      if (!en)
        tog_q <= 1'b0;
      else if (hit && !pwm_mode)
        tog_q <= ~tog_q;
    end
  end

  assign wave = pwm_mode ? (run & (cnt < duty_sh)) : tog_q;

endmodule

// File: rtl/twin_wave_timer.sv
module twin_wave_timer
  import twt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic [W-1:0] period_lo,
  input  logic [W-1:0] period_hi,
  input  logic [W-1:0] duty_lo,
  input  logic [W-1:0] duty_hi,
  output logic         wave_lo,
  output logic         wave_hi,
  output logic         match_lo,
  output logic         match_hi
);

  localparam int NCH = 2;

  twt_mode_e      mode_e;
  logic           run_q;
  logic [W-1:0]   per_in  [NCH];
  logic [W-1:0]   duty_in [NCH];
  logic [W-1:0]   cnt     [NCH];
  logic [W-1:0]   per_sh  [NCH];
  logic [W-1:0]   duty_sh [NCH];
  logic [NCH-1:0] step;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] pwm_sel;
  logic [NCH-1:0] wave;
  logic [NCH-1:0] flag;

  assign mode_e     = twt_mode_e'(mode);
  assign per_in[0]  = period_lo;
  assign per_in[1]  = period_hi;
  assign duty_in[0] = duty_lo;
  assign duty_in[1] = duty_hi;
  assign pwm_sel    = {twt_hi_pwm(mode_e), twt_lo_pwm(mode_e)};
  assign step       = {(twt_chained(mode_e) ? hit[0] : 1'b1), 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    twt_chan #(.W(W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .run     (run_q),
      .step    (step[i]),
      .per_in  (per_in[i]),
      .duty_in (duty_in[i]),
      .hit     (hit[i]),
      .cnt     (cnt[i]),
      .per_sh  (per_sh[i]),
      .duty_sh (duty_sh[i])
    );

    twt_wave #(.W(W)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .run      (run_q),
      .pwm_mode (pwm_sel[i]),
      .hit      (hit[i]),
      .cnt      (cnt[i]),
      .duty_sh  (duty_sh[i]),
      .wave     (wave[i]),
      .flag     (flag[i])
    );
  end

  assign wave_lo  = wave[0];
  assign wave_hi  = wave[1];
  assign match_lo = flag[0];
  assign match_hi = flag[1];

endmodule

// File: rtl/twt_chk.sv
module twt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [1:0]   mode,
  input logic         wave_lo,
  input logic         wave_hi,
  input logic         match_lo,
  input logic         match_hi,
  input logic         run_q,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] cnt1,
  input logic [W-1:0] per0,
  input logic [W-1:0] per1,
  input logic [W-1:0] duty0
);

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en) |-> $stable(mode)) else $error("mode moved while running"); // R10

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(wave_lo || wave_hi || match_lo || match_hi)) else $error("outputs active while off"); // R2

  AST_LO_TOGGLE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(mode) == 2'b00 && mode == 2'b00) |-> ($stable(wave_lo) == !match_lo)) else $error("low toggle off match"); // R3

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && duty0 == '0) |-> !wave_lo) else $error("zero duty not low"); // R5

  AST_WIDE_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode[1]) && match_hi) |-> match_lo) else $error("chained high match alone"); // R8

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt0 <= per0 && cnt1 <= per1)) else $error("count beyond period"); // R9

endmodule

bind twin_wave_timer twt_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .mode     (mode),
  .wave_lo  (wave_lo),
  .wave_hi  (wave_hi),
  .match_lo (match_lo),
  .match_hi (match_hi),
  .run_q    (run_q),
  .cnt0     (cnt[0]),
  .cnt1     (cnt[1]),
  .per0     (per_sh[0]),
  .per1     (per_sh[1]),
  .duty0    (duty_sh[0])
);

// File: tb/tb_twin_wave_timer.sv
module tb_twin_wave_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] period_lo = '0, period_hi = '0, duty_lo = '0, duty_hi = '0;
  logic       wave_lo, wave_hi, match_lo, match_hi;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  twin_wave_timer #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .period_lo(period_lo), .period_hi(period_hi),
    .duty_lo(duty_lo), .duty_hi(duty_hi),
    .wave_lo(wave_lo), .wave_hi(wave_hi),
    .match_lo(match_lo), .match_hi(match_hi)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick_wave(input int sel);
    return sel != 0 ? wave_hi : wave_lo;
  endfunction

  function automatic logic pick_match(input int sel);
    return sel != 0 ? match_hi : match_lo;
  endfunction

  task automatic setup(input logic [1:0] m, input int pl, input int ph, input int dl, input int dh);
    @(negedge clk);
    en = 1'b0;
    mode = m;
    period_lo = 8'(pl); period_hi = 8'(ph);
    duty_lo = 8'(dl);   duty_hi = 8'(dh);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic gap(input int sel, output int g);
    logic prev;
    int t;
    @(negedge clk);
    prev = pick_wave(sel);
    t = 0;
    while (pick_wave(sel) == prev && t < 20000) begin
      @(negedge clk);
      t++;
    end
    prev = pick_wave(sel);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (pick_wave(sel) == prev && g < 20000);
  endtask

  task automatic sync_match(input int sel);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!pick_match(sel) && t < 20000);
  endtask

  task automatic hcount(input int sel, input int n, output int h);
    sync_match(sel);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (pick_wave(sel)) h++;
      @(negedge clk);
    end
  endtask

  task automatic mcount(input int sel, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pick_match(sel)) c++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1 outputs after reset", int'({wave_lo, wave_hi, match_lo, match_hi}), 0);
  endtask

  task automatic t_dual_toggle();
    int g, c, dbl;
    logic last;
    setup(2'b00, 4, 9, 0, 0);
    gap(0, g); check_eq("R3 low toggle gap", g, 5);
    gap(1, g); check_eq("R3 high toggle gap", g, 10);
    mcount(0, 50, c); check_eq("R8 low match count", c, 10);
    mcount(1, 50, c); check_eq("R8 high match count", c, 5);
    dbl = 0; last = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (match_lo && last) dbl++;
      last = match_lo;
    end
    check_eq("R8 match single cycle", dbl, 0);
  endtask

  task automatic t_dual_pwm();
    int h;
    setup(2'b01, 9, 5, 3, 4);
    hcount(0, 10, h); check_eq("R4 low pwm high cycles", h, 3);
    hcount(1, 6, h);  check_eq("R4 high pwm high cycles", h, 4);
  endtask

  task automatic t_duty_edges();
    int h;
    setup(2'b01, 5, 5, 0, 200);
    hcount(0, 12, h); check_eq("R5 zero duty low", h, 0);
    hcount(1, 6, h);  check_eq("R5 large duty high", h, 6);
  endtask

  task automatic t_buffer();
    int h, c;
    setup(2'b01, 9, 5, 3, 0);
    sync_match(0);
    h = 0;
    for (int i = 0; i < 10; i++) begin
      if (wave_lo) h++;
      if (i == 2) begin
        duty_lo = 8'd4;
        period_lo = 8'd4;
      end
      @(negedge clk);
    end
    check_eq("R9 running period keeps old duty", h, 3);
    hcount(0, 5, h); check_eq("R9 new duty applied", h, 4);
    mcount(0, 25, c); check_eq("R9 new period applied", c, 5);
  endtask

  task automatic t_wide_toggle();
    int g, c, lone;
    setup(2'b10, 3, 4, 0, 0);
    gap(0, g); check_eq("R6 low toggle gap", g, 4);
    gap(1, g); check_eq("R6 chained toggle gap", g, 20);
    mcount(1, 100, c); check_eq("R8 chained match count", c, 5);
    lone = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (match_hi && !match_lo) lone++;
    end
    check_eq("R8 high match only with low", lone, 0);
  endtask

  task automatic t_wide_pwm();
    int h, g;
    setup(2'b11, 7, 2, 2, 0);
    hcount(0, 8, h); check_eq("R7 low pwm high cycles", h, 2);
    gap(1, g);       check_eq("R7 chained toggle gap", g, 24);
  endtask

  task automatic t_disable();
    int n, g;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_eq("R2 outputs after disable", int'({wave_lo, wave_hi, match_lo, match_hi}), 0);
    repeat (5) @(negedge clk);
    check_eq("R2 outputs stay low", int'({wave_lo, wave_hi, match_lo, match_hi}), 0);
    mode = 2'b00;
    period_lo = 8'd2;
    period_hi = 8'd7;
    @(negedge clk);
    en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wave_lo && n < 100);
    check_eq("R2 first toggle after enable", n, 4);
    gap(0, g); check_eq("R10 new mode toggle gap", g, 3);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dual_toggle();
    t_dual_pwm();
    t_duty_edges();
    t_buffer();
    t_wide_toggle();
    t_wide_pwm();
    t_disable();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule